// File: doc/BRIEF.md
# Mixed-Cell Boundary Scan Register

This block is the data register that gives board-level test access to a chip's digital pins. It is built as one serial chain from three kinds of cells. An input-only pin has one bit that records the pad level. A three-state output pin has two bits: a drive value and a drive enable. A bidirectional pin has three bits: a captured pad level, a drive value and a drive enable. The number of pins and the kind of each pin are set by parameters. Pins with no cell, such as analog, clock, supply and strapped configuration pins, are simply left out of the list.

An external TAP controller supplies the test clock, the capture, shift and update strobes, and a two-bit code for the current instruction. While SAMPLE/PRELOAD is active, the chain can record the pad levels and be loaded with a pattern, and the pads keep following the core. While EXTEST is active, the pads are driven from the update latches. Under any other instruction the block ignores the strobes, and the pads follow the core. Every drive and enable bit has a shift stage and a separate update latch, so the pads do not change while data moves through the chain.

Top module: `scan_boundary_chain`

## Requirements
- R1: The chain length is the sum of the cell widths: 1 for an input pin, 2 for an output pin and 3 for a bidirectional pin. The kind code of pin i is held in PIN_KINDS[2i+1:2i]: 0 means input, 1 means output, 2 means bidirectional. Bits enter at the highest chain position and leave at position 0. Pin 0 occupies the lowest positions. Inside a cell, the lower positions hold the bits that were shifted in earlier. A pattern shifted in is therefore returned unchanged when the chain is shifted out.
- R2: An input cell has one bit. On a capture strobe it loads the level on pad_in for that pin.
- R3: An output cell holds its drive value at cell offset 0 and its enable at offset 1. Under EXTEST, an enable latch of 1 puts the drive latch on pad_out with pad_oe=1. An enable latch of 0 gives pad_oe=0.
- R4: A bidirectional cell holds its captured pad level at offset 0, its drive value at offset 1 and its enable at offset 2. On capture, offset 0 loads pad_in. Under EXTEST the enable works as in R3.
- R5: The update latches load from the shift stage only on an update strobe. Under EXTEST, pad_out and pad_oe stay steady while the chain shifts.
- R6: On a capture strobe, every drive bit and every enable bit loads the current value of its own update latch.
- R7: tdo carries chain position 0. It changes only on the falling edge of tck.
- R8: When EXTEST is not active, pad_out and pad_oe equal core_out and core_oe for output and bidirectional pins. SAMPLE/PRELOAD capture, shift and update therefore do not disturb the pads. For input pins, pad_out and pad_oe are always 0.
- R9: instr is coded 2'b01 for SAMPLE/PRELOAD and 2'b10 for EXTEST. Any other code is a non-boundary instruction. Under a non-boundary instruction the capture, shift and update strobes have no effect on the chain or on the latches.
- R10: After trst_n is asserted, the chain, the latches and tdo are all 0. EXTEST then drives every pad_oe to 0.
- R11: If capture and shift are both asserted in the same cycle, capture wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tdi | input | 1 | Serial data into the chain |
| dr_capture | input | 1 | Capture strobe from the TAP controller |
| dr_shift | input | 1 | Shift strobe from the TAP controller |
| dr_update | input | 1 | Update strobe from the TAP controller |
| instr | input | 2 | Current instruction code |
| pad_in | input | NUM_PINS | Levels seen at the pins |
| core_out | input | NUM_PINS | Output values from the core |
| core_oe | input | NUM_PINS | Output enables from the core |
| tdo | output | 1 | Serial data out of the chain |
| pad_out | output | NUM_PINS | Value driven toward each pin |
| pad_oe | output | NUM_PINS | Driver enable for each pin |

## Verification
A capture, shift or update strobe acts on the rising tck edge at which it is high. A shifted or captured bit reaches tdo after the falling edge that follows. The bench drives every input and samples every output 5 ns after a falling edge, which lines up with that half-cycle offset. To show that tdo moves on the falling edge, it reads tdo once 2 ns after a rising edge and again after the next falling edge. Pad values are combinational from the instruction and the latches, so the bench reads them in the same cycle as an update strobe or an instruction change, and during a shift it reads them after every single shift.

// File: rtl/bsr_pkg.sv
`timescale 1ns/1ps
package bsr_pkg;

  // Kind of pin a cell serves
  typedef enum logic [1:0] {
    CELL_IN   = 2'd0,
    CELL_OUT  = 2'd1,
    CELL_BIDI = 2'd2
  } cell_kind_e;

  // Instruction codes handed over by the TAP controller
  typedef enum logic [1:0] {
    INS_OTHER  = 2'd0,
    INS_SAMPLE = 2'd1,
    INS_EXTEST = 2'd2
  } scan_ins_e;

  // Number of chain bits a cell of the given kind occupies
  function automatic int cell_width(cell_kind_e kind);
    case (kind)
      CELL_OUT:  return 2;
      CELL_BIDI: return 3;
      default:   return 1;
    endcase
  endfunction

endpackage

// File: rtl/bsr_cell.sv
`timescale 1ns/1ps
module bsr_cell
  import bsr_pkg::*;
#(
  parameter cell_kind_e KIND = CELL_IN
) (
  input  logic tck,
  input  logic trst_n,
  input  logic si,
  input  logic cap_en,
  input  logic shf_en,
  input  logic upd_en,
  input  logic pad_val,
  output logic so,
  output logic drv_q,
  output logic oe_q
);

  localparam int W = cell_width(KIND);

  logic [W-1:0] sh;
  logic [W-1:0] cap_v;
  logic [W-1:0] shift_nxt;
  logic         drv_l;
  logic         oe_l;

  // Shift stage: capture has priority over shift (R11)
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)     sh <= '0;
    else if (cap_en) sh <= cap_v;
    else if (shf_en) sh <= shift_nxt;
  end

  assign so    = sh[0];
  assign drv_q = drv_l;
  assign oe_q  = oe_l;

  generate
    if (W == 1) begin : g_w1
      assign shift_nxt = si;
    end else begin : g_wn
      assign shift_nxt = {si, sh[W-1:1]};
    end

    if (KIND == CELL_OUT) begin : g_out
      // offset 0 drive, offset 1 enable
      assign cap_v = {oe_l, drv_l};
      always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
          drv_l <= 1'b0;
          oe_l  <= 1'b0;
        end else if (upd_en) begin
          drv_l <= sh[0];
          oe_l  <= sh[1];
        end
      end
      logic unused_pad;
      assign unused_pad = pad_val;

      AST_OUT_LATCH_STEADY: assert property (@(posedge tck) disable iff (!trst_n)
        !upd_en |=> ($stable(drv_l) && $stable(oe_l))); // R5
      AST_OUT_CAPTURE_LATCH: assert property (@(posedge tck) disable iff (!trst_n)
        cap_en |=> (sh[1] == $past(oe_l) && sh[0] == $past(drv_l))); // R6
    end else if (KIND == CELL_BIDI) begin : g_bidi
      // offset 0 pad level, offset 1 drive, offset 2 enable
      assign cap_v = {oe_l, drv_l, pad_val};
      always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
          drv_l <= 1'b0;
          oe_l  <= 1'b0;
        end else if (upd_en) begin
          drv_l <= sh[1];
          oe_l  <= sh[2];
        end
      end

      AST_BIDI_LATCH_STEADY: assert property (@(posedge tck) disable iff (!trst_n)
        !upd_en |=> ($stable(drv_l) && $stable(oe_l))); // R5
      AST_BIDI_CAPTURE_PIN: assert property (@(posedge tck) disable iff (!trst_n)
        cap_en |=> (sh[0] == $past(pad_val))); // R4
      AST_BIDI_CAPTURE_LATCH: assert property (@(posedge tck) disable iff (!trst_n)
        cap_en |=> (sh[2] == $past(oe_l) && sh[1] == $past(drv_l))); // R6
    end else begin : g_in
      assign cap_v = pad_val;
      assign drv_l = 1'b0;
      assign oe_l  = 1'b0;
      logic unused_upd;
      assign unused_upd = upd_en;

      AST_IN_CAPTURE_PIN: assert property (@(posedge tck) disable iff (!trst_n)
        cap_en |=> (sh[0] == $past(pad_val))); // R2
    end
  endgenerate

  AST_SHIFT_ENTRY: assert property (@(posedge tck) disable iff (!trst_n)
    (shf_en && !cap_en) |=> (sh[W-1] == $past(si))); // R1

endmodule

// File: rtl/bsr_pin_drive.sv
`timescale 1ns/1ps
module bsr_pin_drive
  import bsr_pkg::*;
#(
  parameter cell_kind_e KIND = CELL_IN
) (
  input  logic extest,
  input  logic core_d,
  input  logic core_e,
  input  logic drv_q,
  input  logic oe_q,
  output logic pad_d,
  output logic pad_e
);

  generate
    if (KIND == CELL_IN) begin : g_in
      // input-only pins never drive
      assign pad_d = 1'b0;
      assign pad_e = 1'b0;
      logic unused_in;
      assign unused_in = ^{extest, core_d, core_e, drv_q, oe_q};
    end else begin : g_drv
      assign pad_d = extest ? drv_q : core_d;
      assign pad_e = extest ? oe_q  : core_e;
    end
  endgenerate

endmodule

// File: rtl/bsr_tdo_stage.sv
`timescale 1ns/1ps
module bsr_tdo_stage (
  input  logic tck,
  input  logic trst_n,
  input  logic chain_end,
  output logic tdo
);

  // Retimed onto the falling edge (R7)
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) tdo <= 1'b0;
    else         tdo <= chain_end;
  end

endmodule

// File: rtl/scan_boundary_chain.sv
`timescale 1ns/1ps
module scan_boundary_chain
  import bsr_pkg::*;
#(
  parameter int                    NUM_PINS  = 5,
  parameter logic [2*NUM_PINS-1:0] PIN_KINDS = 10'b10_01_10_01_00
) (
  input  logic                tck,
  input  logic                trst_n,
  input  logic                tdi,
  input  logic                dr_capture,
  input  logic                dr_shift,
  input  logic                dr_update,
  input  logic [1:0]          instr,
  input  logic [NUM_PINS-1:0] pad_in,
  input  logic [NUM_PINS-1:0] core_out,
  input  logic [NUM_PINS-1:0] core_oe,
  output logic                tdo,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe
);

  logic bs_sel;
  logic extest;
  logic cap_g;
  logic shf_g;
  logic upd_g;
  logic [NUM_PINS:0]   link;
  logic [NUM_PINS-1:0] drv_q;
  logic [NUM_PINS-1:0] oe_q;

  // Strobes act only under a boundary instruction (R9)
  assign bs_sel = (instr == INS_SAMPLE) || (instr == INS_EXTEST);
  assign extest = (instr == INS_EXTEST);
  assign cap_g  = dr_capture & bs_sel;
  assign shf_g  = dr_shift   & bs_sel;
  assign upd_g  = dr_update  & bs_sel;

  assign link[NUM_PINS] = tdi;

  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      localparam cell_kind_e PK = cell_kind_e'(PIN_KINDS[2*i +: 2]);

      bsr_cell #(.KIND(PK)) u_cell (
        .tck     (tck),
        .trst_n  (trst_n),
        .si      (link[i+1]),
        .cap_en  (cap_g),
        .shf_en  (shf_g),
        .upd_en  (upd_g),
        .pad_val (pad_in[i]),
        .so      (link[i]),
        .drv_q   (drv_q[i]),
        .oe_q    (oe_q[i])
      );

      bsr_pin_drive #(.KIND(PK)) u_drive (
        .extest (extest),
        .core_d (core_out[i]),
        .core_e (core_oe[i]),
        .drv_q  (drv_q[i]),
        .oe_q   (oe_q[i]),
        .pad_d  (pad_out[i]),
        .pad_e  (pad_oe[i])
      );
    end
  endgenerate

  bsr_tdo_stage u_tdo (
    .tck       (tck),
    .trst_n    (trst_n),
    .chain_end (link[0]),
    .tdo       (tdo)
  );

  AST_PINS_UNDISTURBED: assert property (@(posedge tck) disable iff (!trst_n)
    (instr != INS_EXTEST && $past(instr) != INS_EXTEST &&
     $stable(core_out) && $stable(core_oe))
    |-> ($stable(pad_out) && $stable(pad_oe))); // R8

  AST_EXTEST_STEADY: assert property (@(posedge tck) disable iff (!trst_n)
    (instr == INS_EXTEST && $past(instr) == INS_EXTEST && !$past(dr_update))
    |-> ($stable(pad_out) && $stable(pad_oe))); // R5

endmodule

// File: tb/scan_boundary_chain_test.sv
`timescale 1ns/1ps
module scan_boundary_chain_test;

  localparam int N = 5;
  localparam int L = 11;
  localparam int KIND [N] = '{0, 1, 2, 1, 2};

  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic tdi = 1'b0;
  logic dr_capture = 1'b0;
  logic dr_shift = 1'b0;
  logic dr_update = 1'b0;
  logic [1:0] instr = 2'b00;
  logic [N-1:0] pad_in = '0;
  logic [N-1:0] core_out = '0;
  logic [N-1:0] core_oe = '0;
  logic tdo;
  logic [N-1:0] pad_out;
  logic [N-1:0] pad_oe;

  int checks = 0;
  int errors = 0;
  int off [N];
  logic m_drv [N];
  logic m_oe  [N];

  logic  exp_q [$];
  string req_q [$];
  event  tdo_ev;

  always #10 tck = ~tck;

  scan_boundary_chain uut (
    .tck(tck), .trst_n(trst_n), .tdi(tdi),
    .dr_capture(dr_capture), .dr_shift(dr_shift), .dr_update(dr_update),
    .instr(instr), .pad_in(pad_in), .core_out(core_out), .core_oe(core_oe),
    .tdo(tdo), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(string rq, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // Monitor: pops each expected serial bit and compares it with tdo
  initial begin
    forever begin
      logic  b;
      string r;
      @(tdo_ev);
      b = exp_q.pop_front();
      r = req_q.pop_front();
      check(r, {15'd0, tdo}, {15'd0, b});
    end
  end

  // Watchdog
  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic int kwidth(int k);
    return (k == 0) ? 1 : (k == 1) ? 2 : 3;
  endfunction

  function automatic logic [L-1:0] cap_expect(logic [N-1:0] pads);
    logic [L-1:0] v = '0;
    for (int i = 0; i < N; i++) begin
      if (KIND[i] == 0) v[off[i]] = pads[i];
      else if (KIND[i] == 1) begin
        v[off[i]] = m_drv[i]; v[off[i]+1] = m_oe[i];
      end else begin
        v[off[i]] = pads[i]; v[off[i]+1] = m_drv[i]; v[off[i]+2] = m_oe[i];
      end
    end
    return v;
  endfunction

  task automatic model_update(logic [L-1:0] v);
    for (int i = 0; i < N; i++) begin
      if (KIND[i] == 1) begin m_drv[i] = v[off[i]];   m_oe[i] = v[off[i]+1]; end
      if (KIND[i] == 2) begin m_drv[i] = v[off[i]+1]; m_oe[i] = v[off[i]+2]; end
    end
  endtask

  task automatic check_pads(string rq, bit ext);
    logic [N-1:0] eo = '0;
    logic [N-1:0] ee = '0;
    for (int i = 0; i < N; i++) begin
      if (KIND[i] != 0) begin
        eo[i] = ext ? m_drv[i] : core_out[i];
        ee[i] = ext ? m_oe[i]  : core_oe[i];
      end
    end
    check({rq, " pad_out"}, {11'd0, pad_out}, {11'd0, eo});
    check({rq, " pad_oe"},  {11'd0, pad_oe},  {11'd0, ee});
  endtask

  // One full cycle; returns 5 ns after the falling edge
  task automatic tick();
    @(posedge tck);
    @(negedge tck);
    #5;
  endtask

  task automatic pulse_capture();
    dr_capture = 1'b1; tick(); dr_capture = 1'b0;
  endtask

  task automatic pulse_update();
    dr_update = 1'b1; tick(); dr_update = 1'b0;
  endtask

  // Driver: pushes the expected outgoing bit, then shifts one bit in
  task automatic scan(logic [L-1:0] vin, logic [L-1:0] vexp, string rq, bit watch);
    for (int k = 0; k < L; k++) begin
      exp_q.push_back(vexp[k]);
      req_q.push_back(rq);
      ->tdo_ev;
      tdi = vin[k];
      dr_shift = 1'b1;
      tick();
      if (watch) check_pads("R5", 1'b1);
    end
    dr_shift = 1'b0;
  endtask

  initial begin
    logic [L-1:0] p1;
    logic [L-1:0] qv;
    logic [L-1:0] rv;
    logic [L-1:0] vv;
    logic [L-1:0] e;
    p1 = 11'b00110011100;
    qv = 11'b10010010110;
    rv = 11'b01101101001;
    vv = 11'b00000000101;
    off[0] = 0;
    for (int i = 1; i < N; i++) off[i] = off[i-1] + kwidth(KIND[i-1]);
    check("R1 chain length", 16'(off[N-1] + kwidth(KIND[N-1])), 16'(L));
    for (int i = 0; i < N; i++) begin m_drv[i] = 1'b0; m_oe[i] = 1'b0; end

    // R10 reset
    core_out = 5'b10110;
    core_oe  = 5'b01011;
    tick(); tick();
    check("R10 tdo in reset", {15'd0, tdo}, 16'd0);
    trst_n = 1'b1;
    tick();
    check("R10 tdo after reset", {15'd0, tdo}, 16'd0);
    check_pads("R8 other instr", 1'b0);
    instr = 2'b10;
    #1;
    check_pads("R10 extest after reset", 1'b1);
    check("R10 all enables off", {11'd0, pad_oe}, 16'd0);

    // SAMPLE/PRELOAD capture and preload
    instr  = 2'b01;
    pad_in = 5'b10101;
    pulse_capture();
    e = cap_expect(pad_in);
    scan(p1, e, "R2/R4/R6 sample capture", 1'b0);
    check_pads("R8 sample after shift", 1'b0);
    pulse_update();
    model_update(p1);
    check_pads("R8 sample after update", 1'b0);
    core_out = 5'b01001;
    core_oe  = 5'b10110;
    #1;
    check_pads("R8 core follow", 1'b0);

    // Drive and enable bits capture latch values
    pad_in = 5'b01010;
    pulse_capture();
    e = cap_expect(pad_in);
    scan(qv, e, "R6 latch capture", 1'b0);
    pulse_update();
    model_update(qv);

    // EXTEST drives latches
    instr = 2'b10;
    #1;
    check_pads("R3/R4 extest", 1'b1);

    // Shift under EXTEST: pads steady, then update applies
    scan(rv, qv, "R1 roundtrip", 1'b1);
    pulse_update();
    model_update(rv);
    check_pads("R3/R4 extest new pattern", 1'b1);

    // Non-boundary instruction: strobes ignored
    instr = 2'b00;
    tdi = 1'b1;
    dr_shift = 1'b1; tick(); tick(); tick(); dr_shift = 1'b0;
    pulse_capture();
    pulse_update();
    check_pads("R8 other after strobes", 1'b0);
    instr = 2'b10;
    #1;
    check_pads("R9 latches kept", 1'b1);
    instr = 2'b11;
    dr_update = 1'b1; tick(); dr_update = 1'b0;
    instr = 2'b01;
    scan('0, rv, "R9 chain kept", 1'b0);
    instr = 2'b10;
    #1;
    check_pads("R9 code 3 update ignored", 1'b1);

    // Capture wins over shift
    instr  = 2'b01;
    pad_in = 5'b11011;
    tdi = 1'b0;
    dr_capture = 1'b1; dr_shift = 1'b1;
    tick();
    dr_capture = 1'b0; dr_shift = 1'b0;
    e = cap_expect(pad_in);
    scan(vv, e, "R11 capture priority", 1'b0);

    // tdo moves on the falling edge only
    tdi = 1'b0;
    dr_shift = 1'b1;
    @(posedge tck);
    #2;
    check("R7 tdo before falling edge", {15'd0, tdo}, 16'd1);
    @(negedge tck);
    #2;
    check("R7 tdo after falling edge", {15'd0, tdo}, 16'd0);
    #3;
    dr_shift = 1'b0;
    tick();

    check("R1 monitor queue drained", 16'(exp_q.size()), 16'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule